// File: doc/BRIEF.md
# Console Host Register Interface

This block sits on the system side of a processor debug console and lets a host controller run console commands one at a time. The host hands over a command code, and optionally an operand, through a valid/ready port. The block stores them in registers that the processor polls over its IO bus. It then frames the command on an active-low request line. The line falls and is held low for a programmable number of cycles. It is then released high, and that rising edge starts the command. The processor writes its result to a fixed IO address. The block captures that value and presents it to the host for one cycle.

A continue command returns the processor to normal execution, so it produces no result. The block recognises the continue code and completes as soon as the request line goes high. Two more addresses are decoded while the console is active. They have no function: reads of them return zero and writes to them are dropped.

The sequencer has four states:
- IDLE: ready for a new host command. The request line is high.
- HOLD: the request line is low and a cycle counter runs.
- AWAIT: the request line is high and the block waits for the result write.
- DONE: the completion is presented to the host for one cycle.

Its transitions are:
- IDLE→HOLD when a command is accepted.
- HOLD→AWAIT when the counter expires, for an ordinary command.
- HOLD→DONE when the counter expires, for the continue code.
- AWAIT→DONE on the processor's result write.
- DONE→IDLE unconditionally.

Top module: `con_host_iface`

## Requirements
- R1: After reset, `conreq_n` is 1, `host_ready` is 1, `done_valid` is 0, `done_data` is 0, and reads of the command, operand and result addresses return 0.
- R2: A command is accepted at a clock edge where `host_valid` and `host_ready` are both 1. At that same edge the command register loads `host_cmd`. The operand register loads `host_opnd` only if `host_has_opnd` is 1. `conreq_n` reads 0 in the cycle that follows.
- R3: Once low, `conreq_n` stays low for exactly MIN_LOW cycles (MIN_LOW ≥ 2) and then returns to 1. It never changes again until the next command is accepted.
- R4: While `con_active` is 1, a read (`io_rd`=1) of 0x8402 returns the command register and a read of 0xC000 returns the operand register. Both registers change only when a command is accepted, so they are stable throughout the low phase and across the rising edge. Without a new operand, the operand register keeps its previous value.
- R5: For any code other than CONT_CODE, after `conreq_n` rises the block waits in AWAIT. The result arrives as an IO write (`io_wr`=1, `con_active`=1) to 0x4000. In the next cycle `done_valid` is 1 for exactly one cycle, and `done_data` equals the written value.
- R6: When the command equals CONT_CODE, `done_valid` is 1 in the first cycle in which `conreq_n` is back at 1, and `done_data` is 0.
- R7: `host_ready` is 0 from the cycle after acceptance through the `done_valid` cycle. While `host_ready` is 0, `host_valid` has no effect on any register or output.
- R8: With `con_active` = 1, reads of 0xC001 and 0x4001 return 0, and writes to them change no register.
- R9: Reads of 0xC000 have no side effects. Repeated reads return the same value and do not disturb the sequence.
- R10: With `con_active` = 0, every read returns 0 and a write to 0x4000 is ignored. A write to 0x4000 outside AWAIT is also ignored.
- R11: With `con_active` = 1, a read of 0x4000 returns the last captured result.
- R12: `done_data` is 0 in every cycle in which `done_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_valid | input | 1 | Host offers a command |
| host_ready | output | 1 | Block can accept a command |
| host_cmd | input | DW | Command code |
| host_opnd | input | DW | Operand value |
| host_has_opnd | input | 1 | Load `host_opnd` together with the command |
| done_valid | output | 1 | One-cycle completion strobe |
| done_data | output | DW | Captured result (0 for continue) |
| con_active | input | 1 | Processor is in console mode; enables IO decode |
| io_addr | input | 16 | Processor IO address |
| io_rd | input | 1 | Processor IO read |
| io_wr | input | 1 | Processor IO write |
| io_wdata | input | DW | Processor IO write data |
| io_rdata | output | DW | Processor IO read data (combinational) |
| conreq_n | output | 1 | Active-low console request line |

## Verification
The bench builds the block with MIN_LOW = 3, DW = 16 and CONT_CODE = 0x0007. A hold of three cycles shows the low-phase counter follows the parameter rather than a fixed two. It also leaves room for IO writes and operand reads while the line is still low. The default continue code lets the bench run a continue command after ordinary ones, and compare its immediate, result-free completion with the AWAIT path.

// File: rtl/con_pkg.sv
package con_pkg;
    // Processor IO map seen by this block
    localparam logic [15:0] ADDR_CMD  = 16'h8402;
    localparam logic [15:0] ADDR_DIN  = 16'hC000;
    localparam logic [15:0] ADDR_DOUT = 16'h4000;
    localparam logic [15:0] ADDR_NUL0 = 16'hC001;
    localparam logic [15:0] ADDR_NUL1 = 16'h4001;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HOLD,
        ST_AWAIT,
        ST_DONE
    } seq_st_t;
endpackage

// File: rtl/con_regs.sv
module con_regs
    import con_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] host_cmd,
    input  logic [DW-1:0] host_opnd,
    input  logic          host_has_opnd,
    input  logic          capture_en,
    input  logic          con_active,
    input  logic [15:0]   io_addr,
    input  logic          io_rd,
    input  logic          io_wr,
    input  logic [DW-1:0] io_wdata,
    output logic [DW-1:0] io_rdata,
    output logic [DW-1:0] cmd_q,
    output logic [DW-1:0] res_q,
    output logic          res_hit
);
    logic [DW-1:0] opnd_q;
    logic          res_we;

    assign res_hit = con_active && io_wr && (io_addr == ADDR_DOUT);
    assign res_we  = res_hit && capture_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            opnd_q <= '0;
            res_q  <= '0;
        end else begin
            if (load) begin
                cmd_q <= host_cmd;
                if (host_has_opnd) opnd_q <= host_opnd;
            end
            if (res_we) res_q <= io_wdata;
        end
    end

    // Read port: side-effect free, the two spare addresses read as zero
    always_comb begin
        io_rdata = '0;
        if (con_active && io_rd) begin
            case (io_addr)
                ADDR_CMD:  io_rdata = cmd_q;
                ADDR_DIN:  io_rdata = opnd_q;
                ADDR_DOUT: io_rdata = res_q;
                ADDR_NUL0: io_rdata = '0;
                ADDR_NUL1: io_rdata = '0;
                default:   io_rdata = '0;
            endcase
        end
    end

    // R4
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(cmd_q));
    // R4
    opnd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(opnd_q));
    // R10
    res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_we |=> $stable(res_q));
endmodule

// File: rtl/con_seq.sv
module con_seq
    import con_pkg::*;
#(
    parameter int MIN_LOW = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic host_valid,
    input  logic is_cont,
    input  logic res_hit,
    output logic host_ready,
    output logic accept,
    output logic capture_en,
    output logic done_valid,
    output logic conreq_n
);
    localparam int            CW   = $clog2(MIN_LOW + 1);
    localparam logic [CW-1:0] LAST = CW'(MIN_LOW - 1);
    localparam logic [CW-1:0] FULL = CW'(MIN_LOW);

    seq_st_t       st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // Next-state logic
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            ST_IDLE: begin
                if (host_valid) begin
                    st_d  = ST_HOLD;
                    cnt_d = '0;
                end
            end
            ST_HOLD: begin
                if (cnt_q == LAST) st_d = is_cont ? ST_DONE : ST_AWAIT;
                else               cnt_d = cnt_q + CW'(1);
            end
            ST_AWAIT: begin
                if (res_hit) st_d = ST_DONE;
            end
            ST_DONE: st_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        host_ready = (st_q == ST_IDLE);
        accept     = (st_q == ST_IDLE) && host_valid;
        capture_en = (st_q == ST_AWAIT);
        done_valid = (st_q == ST_DONE);
        conreq_n   = (st_q != ST_HOLD);
    end

    // Independent length count of the low phase, for checking only
    logic [CW-1:0] low_len;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              low_len <= '0;
        else if (conreq_n)       low_len <= '0;
        else if (low_len != FULL) low_len <= low_len + CW'(1);
    end

    // R3
    low_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conreq_n) |-> (low_len == FULL));
    // R7
    ready_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_ready && done_valid));
    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid);
    // R6
    cont_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(conreq_n) && is_cont) |-> done_valid);
    // R2
    accept_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !conreq_n);
endmodule

// File: rtl/con_host_iface.sv
module con_host_iface
    import con_pkg::*;
#(
    parameter int            DW        = 16,
    parameter int            MIN_LOW   = 2,
    parameter logic [DW-1:0] CONT_CODE = DW'(7)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_valid,
    output logic          host_ready,
    input  logic [DW-1:0] host_cmd,
    input  logic [DW-1:0] host_opnd,
    input  logic          host_has_opnd,
    output logic          done_valid,
    output logic [DW-1:0] done_data,
    input  logic          con_active,
    input  logic [15:0]   io_addr,
    input  logic          io_rd,
    input  logic          io_wr,
    input  logic [DW-1:0] io_wdata,
    output logic [DW-1:0] io_rdata,
    output logic          conreq_n
);
    logic [DW-1:0] cmd_q, res_q;
    logic          accept, capture_en, res_hit, is_cont;

    assign is_cont = (cmd_q == CONT_CODE);

    con_regs #(.DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .load(accept),
        .host_cmd(host_cmd), .host_opnd(host_opnd), .host_has_opnd(host_has_opnd),
        .capture_en(capture_en), .con_active(con_active),
        .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .cmd_q(cmd_q), .res_q(res_q), .res_hit(res_hit)
    );

    con_seq #(.MIN_LOW(MIN_LOW)) u_seq (
        .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .is_cont(is_cont),
        .res_hit(res_hit), .host_ready(host_ready), .accept(accept),
        .capture_en(capture_en), .done_valid(done_valid), .conreq_n(conreq_n)
    );

    assign done_data = (done_valid && !is_cont) ? res_q : '0;

    // R12
    done_data_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_valid |-> (done_data == '0));
endmodule

// File: tb/sim_con_host_iface.sv
`timescale 1ns/1ps
module sim_con_host_iface;
    localparam int          DW      = 16;
    localparam int          MIN_LOW = 3;
    localparam logic [15:0] CONT    = 16'h0007;

    logic          clk = 0, rst_n = 0;
    logic          host_valid = 0, host_has_opnd = 0;
    logic [DW-1:0] host_cmd = '0, host_opnd = '0;
    logic          host_ready, done_valid, conreq_n;
    logic [DW-1:0] done_data, io_rdata;
    logic          con_active = 0, io_rd = 0, io_wr = 0;
    logic [15:0]   io_addr = '0;
    logic [DW-1:0] io_wdata = '0;

    int checks = 0, fails = 0, cyc = 0;
    bit fin = 0;

    always #2.5 clk = ~clk;

    con_host_iface #(.DW(DW), .MIN_LOW(MIN_LOW), .CONT_CODE(CONT)) u0 (
        .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_ready(host_ready),
        .host_cmd(host_cmd), .host_opnd(host_opnd), .host_has_opnd(host_has_opnd),
        .done_valid(done_valid), .done_data(done_data), .con_active(con_active),
        .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .conreq_n(conreq_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference: phase 0 idle, 1 low, 2 waiting, 3 complete
    int            m_phase = 0, m_left = 0;
    logic [DW-1:0] m_cmd = '0, m_opnd = '0, m_res = '0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_phase = 0; m_left = 0; m_cmd = '0; m_opnd = '0; m_res = '0;
        end else begin
            case (m_phase)
                0: if (host_valid) begin
                       m_cmd = host_cmd;
                       if (host_has_opnd) m_opnd = host_opnd;
                       m_phase = 1; m_left = MIN_LOW;
                   end
                1: begin
                       m_left--;
                       if (m_left == 0) m_phase = (m_cmd == CONT) ? 3 : 2;
                   end
                2: if (io_wr && con_active && io_addr == 16'h4000) begin
                       m_res = io_wdata; m_phase = 3;
                   end
                default: m_phase = 0;
            endcase
        end
    end

    function automatic logic [DW-1:0] m_rdata();
        if (!(io_rd && con_active)) return '0;
        case (io_addr)
            16'h8402: return m_cmd;
            16'hC000: return m_opnd;
            16'h4000: return m_res;
            default:  return '0;
        endcase
    endfunction

    always @(negedge clk) begin
        if (rst_n && !fin) begin
            chk("R3 conreq_n", conreq_n, (m_phase == 1) ? 0 : 1);
            chk("R7 host_ready", host_ready, (m_phase == 0) ? 1 : 0);
            chk("R5 done_valid", done_valid, (m_phase == 3) ? 1 : 0);
            chk("R12 done_data", done_data,
                (m_phase == 3 && m_cmd != CONT) ? m_res : '0);
            chk("R4 io_rdata", io_rdata, m_rdata());
        end
    end

    task automatic report();
        fin = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !fin) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            report();
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic send(input logic [15:0] c, input logic [15:0] o, input logic h);
        while (!host_ready) step();
        host_cmd = c; host_opnd = o; host_has_opnd = h; host_valid = 1;
        step();
        host_valid = 0;
    endtask

    task automatic rd_chk(input logic [15:0] a, input logic [15:0] exp, input string req);
        io_addr = a; io_rd = 1;
        #0.5;
        chk(req, io_rdata, exp);
        step();
        io_rd = 0;
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        io_addr = a; io_wdata = d; io_wr = 1;
        step();
        io_wr = 0;
    endtask

    task automatic wait_high();
        while (!conreq_n) step();
    endtask

    initial begin
        int n;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 conreq_n", conreq_n, 1);
        chk("R1 host_ready", host_ready, 1);
        chk("R1 done_valid", done_valid, 0);
        con_active = 1;
        rst_n = 1;
        rd_chk(16'h8402, 16'h0000, "R1");
        rd_chk(16'h4000, 16'h0000, "R1");

        // Ordinary command with operand
        send(16'h0012, 16'hBEEF, 1);
        chk("R2 conreq_n low", conreq_n, 0);
        wr(16'h4000, 16'h7777);                 // too early, ignored
        rd_chk(16'h4000, 16'h0000, "R10");
        rd_chk(16'hC000, 16'hBEEF, "R9");
        wait_high();
        rd_chk(16'hC000, 16'hBEEF, "R9");
        rd_chk(16'h8402, 16'h0012, "R4");
        wr(16'hC001, 16'h1111);
        wr(16'h4001, 16'h2222);
        rd_chk(16'hC001, 16'h0000, "R8");
        rd_chk(16'h4001, 16'h0000, "R8");
        rd_chk(16'h4000, 16'h0000, "R8");
        chk("R5 still waiting", done_valid, 0);
        wr(16'h4000, 16'h5A5A);
        chk("R5 done_valid", done_valid, 1);
        chk("R5 done_data", done_data, 16'h5A5A);
        step();
        chk("R5 one cycle", done_valid, 0);
        rd_chk(16'h4000, 16'h5A5A, "R11");

        // Command without operand; busy offers are ignored
        send(16'h0021, 16'h1234, 0);
        host_cmd = 16'h0055; host_valid = 1;
        #0.5;
        chk("R7 ready low while busy", host_ready, 0);
        step();
        host_valid = 0;
        rd_chk(16'hC000, 16'hBEEF, "R4");
        wait_high();
        con_active = 0;
        rd_chk(16'h8402, 16'h0000, "R10");
        wr(16'h4000, 16'hDEAD);
        chk("R10 write ignored", done_valid, 0);
        con_active = 1;
        rd_chk(16'h8402, 16'h0021, "R7");
        wr(16'h4000, 16'h0BAD);
        chk("R5 done_data", done_data, 16'h0BAD);

        // Continue command
        send(CONT, 16'h0000, 0);
        n = 0;
        while (!done_valid && n < 50) begin step(); n++; end
        chk("R6 done_valid", done_valid, 1);
        chk("R6 conreq_n high", conreq_n, 1);
        chk("R6 done_data", done_data, 16'h0000);
        chk("R3 hold length", n, MIN_LOW);
        rd_chk(16'h4000, 16'h0BAD, "R11");

        repeat (4) step();
        report();
    end
endmodule